// File: doc/BRIEF.md
# Shuffled-Schedule Binary Field Multiplier

This block multiplies two elements of GF(2^M) in polynomial basis. By default M is 233 and the reduction trinomial is x^233 + x^74 + 1. Both operands are zero-extended to four equal segments. The product is built from nine partial products that follow a two-level Karatsuba split. A single schoolbook carry-less multiplier computes all nine, one per clock cycle. Each partial product is shifted into every position the Karatsuba recombination needs, XORed into the accumulator, and the accumulator is folded back to M bits in that same cycle.

The order of the nine partial products is drawn again for every multiplication, so that the power profile of the multiplier does not repeat from one call to the next. When a multiplication is accepted, an LFSR is loaded from the seed input. A Fisher–Yates shuffle driven by that LFSR then swaps one pair of order entries per cycle for eight cycles. The nine accumulation cycles follow the shuffle. The enclosing point-multiplication controller provides the operands and a fresh seed, and it waits for the done pulse.

Top module: `rand_order_gf_mul`

## Requirements
- R1: After reset, ready is 1, done is 0 and result is all zeros.
- R2: When start is high while ready is 1, the block takes op_a, op_b and seed on that clock edge. Ready is 0 from the next cycle until done has been raised.
- R3: Done rises on the 17th rising edge after the accepting edge: 8 shuffle cycles, then 9 partial-product cycles. Done stays high for exactly one cycle, and ready returns to 1 in that same cycle.
- R4: Result equals the carry-less product of op_a and op_b reduced modulo x^M + x^TAP + 1. Bit i of each operand and of the result is the coefficient of x^i.
- R5: The schedule is a permutation of the nine partial products, drawn again for each multiplication from the seed. The result does not depend on the seed.
- R6: A start that arrives while ready is 0 is ignored. It does not replace the operands in flight and does not cause a further done.
- R7: Result holds its value in every cycle, except the cycle that follows the edge on which done is raised.
- R8: A seed of zero still gives a live random source, and the product is still correct.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request a multiplication |
| ready | output | 1 | Block is idle and will accept start |
| op_a | input | M | First field element |
| op_b | input | M | Second field element |
| seed | input | SEED_W | Seed for the schedule randomizer |
| result | output | M | Reduced product, held until the next completion |
| done | output | 1 | One-cycle pulse when result is updated |

## Verification
The bench builds one instance with M=5 and TAP=2, which gives 2-bit segments and a 15-bit shifted-contribution width. With this size every one of the 1024 operand pairs can be run, each with a different seed (zero among them), so every Karatsuba placement and every reduction fold is reached under many schedules. A second instance uses the default 233-bit field with x^74 as the middle term. It runs a dozen vectors that include the top-degree operands, where the reduction must fold repeatedly. Busy-time starts, the length of the done pulse and the holding of the result are checked on the small instance.

// File: rtl/rogf_pkg.sv
package rogf_pkg;
  localparam int NPP   = 9;  // partial products per multiplication
  localparam int IDX_W = 4;  // width of a partial-product index
  localparam int NSH   = 7;  // segment shift positions 0..6

  typedef logic [IDX_W-1:0] pp_idx_t;
  typedef enum logic [1:0] {ST_IDLE, ST_SHUF, ST_MUL} ctl_st_t;

  // Segment offsets (in units of the segment width) where a partial product
  // lands after both Karatsuba levels are recombined.
  function automatic logic [NSH-1:0] place_mask(input pp_idx_t k);
    case (k)
      4'd0:    place_mask = 7'b0001111; // a0*b0
      4'd1:    place_mask = 7'b0011110; // a1*b1
      4'd2:    place_mask = 7'b0001010; // (a0+a1)(b0+b1)
      4'd3:    place_mask = 7'b0111100; // a2*b2
      4'd4:    place_mask = 7'b1111000; // a3*b3
      4'd5:    place_mask = 7'b0101000; // (a2+a3)(b2+b3)
      4'd6:    place_mask = 7'b0001100; // (a0+a2)(b0+b2)
      4'd7:    place_mask = 7'b0011000; // (a1+a3)(b1+b3)
      4'd8:    place_mask = 7'b0001000; // sum of all four pairs
      default: place_mask = '0;
    endcase
  endfunction
endpackage

// File: rtl/rogf_clmul.sv
module rogf_clmul #(
  parameter int W = 59
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-2:0] p
);
  // Schoolbook carry-less product: coefficient n is the XOR of a[i]&b[j], i+j=n.
  always_comb begin
    p = '0;
    for (int i = 0; i < W; i++) begin
      for (int j = 0; j < W; j++) begin
        p[i+j] = p[i+j] ^ (a[i] & b[j]);
      end
    end
  end
endmodule

// File: rtl/rogf_lfsr.sv
module rogf_lfsr #(
  parameter int          SW    = 16,
  parameter logic [SW-1:0] TAPS = 16'hB400,
  parameter int          OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [SW-1:0]    seed,
  input  logic             adv,
  output logic [OUT_W-1:0] rnd
);
  logic [SW-1:0] s_q, s_nxt;

  // Advance OUT_W Galois steps per cycle so each draw uses fresh bits.
  always_comb begin
    s_nxt = s_q;
    for (int k = 0; k < OUT_W; k++) begin
      s_nxt = s_nxt[0] ? ((s_nxt >> 1) ^ TAPS) : (s_nxt >> 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)       s_q <= SW'(1);
    else if (load) s_q <= (seed == '0) ? SW'(1) : seed;
    else if (adv)  s_q <= s_nxt;
  end

  assign rnd = s_q[OUT_W-1:0];

  // R8: the state never collapses to the all-zero lock-up value
  p_lfsr_live_r8: assert property (@(posedge clk) disable iff (rst) s_q != '0);
endmodule

// File: rtl/rogf_shuffle.sv
module rogf_shuffle
  import rogf_pkg::*;
#(
  parameter int RND_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             step,
  input  logic [RND_W-1:0] rnd,
  input  pp_idx_t          rd_pos,
  output pp_idx_t          rd_val,
  output logic             last
);
  localparam int PW = RND_W + IDX_W;

  pp_idx_t        ord_q [NPP];
  pp_idx_t        pos_q;
  pp_idx_t        pick;
  logic [PW-1:0]  scaled;

  // Pick an index in 0..pos by scaling the random draw: floor(rnd*(pos+1)/2^RND_W).
  assign scaled = {{IDX_W{1'b0}}, rnd} * {{RND_W{1'b0}}, pos_q + 1'b1};
  assign pick   = scaled[RND_W +: IDX_W];
  assign last   = (pos_q == pp_idx_t'(1));

  always_ff @(posedge clk) begin
    if (rst || init) begin
      for (int k = 0; k < NPP; k++) ord_q[k] <= pp_idx_t'(k);
      pos_q <= pp_idx_t'(NPP - 1);
    end else if (step) begin
      ord_q[pos_q] <= ord_q[pick];
      ord_q[pick]  <= ord_q[pos_q];
      pos_q        <= pos_q - 1'b1;
    end
  end

  assign rd_val = ord_q[rd_pos];

  logic [(1<<IDX_W)-1:0] seen;
  always_comb begin
    seen = '0;
    for (int k = 0; k < NPP; k++) seen[ord_q[k]] = 1'b1;
  end

  // R5: the schedule always names each of the nine partial products once
  p_perm_valid_r5: assert property (@(posedge clk) disable iff (rst)
    ($countones(seen) == NPP) && (seen[(1<<IDX_W)-1:NPP] == '0));
endmodule

// File: rtl/rogf_reduce.sv
module rogf_reduce #(
  parameter int IN_W = 471,
  parameter int M    = 233,
  parameter int TAP  = 74
) (
  input  logic [IN_W-1:0] din,
  output logic [M-1:0]    dout
);
  logic [IN_W-1:0] v;

  // Fold from the top: x^i = x^(i-M) * (x^TAP + 1). Since TAP < M, every
  // folded term lands below i and is handled by a later iteration.
  always_comb begin
    v = din;
    for (int i = IN_W - 1; i >= M; i--) begin
      if (v[i]) begin
        v[i]         = 1'b0;
        v[i-M]       = ~v[i-M];
        v[i-M+TAP]   = ~v[i-M+TAP];
      end
    end
  end

  assign dout = v[M-1:0];
endmodule

// File: rtl/rand_order_gf_mul.sv
module rand_order_gf_mul
  import rogf_pkg::*;
#(
  parameter int              M       = 233,
  parameter int              TAP     = 74,
  parameter int              SEED_W  = 16,
  parameter logic [SEED_W-1:0] LFSR_TAPS = 16'hB400,
  parameter int              RND_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              ready,
  input  logic [M-1:0]      op_a,
  input  logic [M-1:0]      op_b,
  input  logic [SEED_W-1:0] seed,
  output logic [M-1:0]      result,
  output logic              done
);
  localparam int W     = (M + 3) / 4;   // segment width
  localparam int PADW  = 4 * W;         // zero-extended operand width
  localparam int CW    = 2 * W - 1;     // partial product width
  localparam int XW    = 8 * W - 1;     // widest shifted contribution
  localparam int LAT   = 2 * NPP - 1;   // accept edge to done edge
  localparam int CNT_W = $clog2(LAT + 1) + 1;

  ctl_st_t      st_q;
  logic [M-1:0] a_q, b_q, acc_q, res_q, acc_nxt;
  pp_idx_t      cnt_q, cur_idx;
  logic         done_q, shuf_last;
  logic [RND_W-1:0] rnd;

  wire accept = (st_q == ST_IDLE) && start;

  rogf_lfsr #(.SW(SEED_W), .TAPS(LFSR_TAPS), .OUT_W(RND_W)) u_rng (
    .clk(clk), .rst(rst), .load(accept), .seed(seed),
    .adv(st_q == ST_SHUF), .rnd(rnd)
  );

  rogf_shuffle #(.RND_W(RND_W)) u_ord (
    .clk(clk), .rst(rst), .init(accept), .step(st_q == ST_SHUF),
    .rnd(rnd), .rd_pos(cnt_q), .rd_val(cur_idx), .last(shuf_last)
  );

  // Operand segments and the pair feeding the current partial product
  logic [PADW-1:0] a_pad, b_pad;
  logic [W-1:0]    as [4];
  logic [W-1:0]    bs [4];
  logic [W-1:0]    sel_a, sel_b;
  logic [CW-1:0]   pp;

  assign a_pad = PADW'(a_q);
  assign b_pad = PADW'(b_q);

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      as[k] = a_pad[k*W +: W];
      bs[k] = b_pad[k*W +: W];
    end
    case (cur_idx)
      4'd0:    begin sel_a = as[0];         sel_b = bs[0];         end
      4'd1:    begin sel_a = as[1];         sel_b = bs[1];         end
      4'd2:    begin sel_a = as[0] ^ as[1]; sel_b = bs[0] ^ bs[1]; end
      4'd3:    begin sel_a = as[2];         sel_b = bs[2];         end
      4'd4:    begin sel_a = as[3];         sel_b = bs[3];         end
      4'd5:    begin sel_a = as[2] ^ as[3]; sel_b = bs[2] ^ bs[3]; end
      4'd6:    begin sel_a = as[0] ^ as[2]; sel_b = bs[0] ^ bs[2]; end
      4'd7:    begin sel_a = as[1] ^ as[3]; sel_b = bs[1] ^ bs[3]; end
      default: begin
        sel_a = as[0] ^ as[1] ^ as[2] ^ as[3];
        sel_b = bs[0] ^ bs[1] ^ bs[2] ^ bs[3];
      end
    endcase
  end

  rogf_clmul #(.W(W)) u_pm (.a(sel_a), .b(sel_b), .p(pp));

  // Scatter the partial product into all its recombination offsets
  logic [NSH-1:0] msk;
  logic [XW-1:0]  contrib, unreduced;

  assign msk = place_mask(cur_idx);

  always_comb begin
    contrib = '0;
    for (int s = 0; s < NSH; s++) begin
      if (msk[s]) contrib = contrib ^ (XW'(pp) << (s * W));
    end
    unreduced = contrib ^ XW'(acc_q);
  end

  rogf_reduce #(.IN_W(XW), .M(M), .TAP(TAP)) u_red (.din(unreduced), .dout(acc_nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      a_q    <= '0;
      b_q    <= '0;
      acc_q  <= '0;
      res_q  <= '0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (start) begin
          a_q   <= op_a;
          b_q   <= op_b;
          acc_q <= '0;
          st_q  <= ST_SHUF;
        end
        ST_SHUF: if (shuf_last) begin
          cnt_q <= '0;
          st_q  <= ST_MUL;
        end
        default: begin
          acc_q <= acc_nxt;
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == pp_idx_t'(NPP - 1)) begin
            res_q  <= acc_nxt;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end
        end
      endcase
    end
  end

  assign ready  = (st_q == ST_IDLE);
  assign result = res_q;
  assign done   = done_q;

  // Cycle counter and history flag used only by the checks below
  logic [CNT_W-1:0] busy_cyc;
  logic             past_ok;
  always_ff @(posedge clk) begin
    if (rst || st_q == ST_IDLE) busy_cyc <= '0;
    else                        busy_cyc <= busy_cyc + 1'b1;
    past_ok <= !rst;
  end

  // R2: an accepted start drops ready on the next cycle
  p_ready_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (start && ready) |=> !ready);
  // R3: done is a single-cycle pulse
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R3: done arrives a fixed number of cycles after acceptance
  p_latency_r3: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy_cyc == CNT_W'(LAT)));
  // R6: operands in flight are untouched while busy
  p_busy_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!ready) |=> ($stable(a_q) && $stable(b_q)));
  // R7: result only moves together with done
  p_result_hold_r7: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !done |-> $stable(result));
endmodule

// File: tb/tb_rand_order_gf_mul.sv
module tb_rand_order_gf_mul;
  logic clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  logic rst;
  int checks = 0;
  int fails  = 0;

  // Small instance: M=5, x^5 + x^2 + 1
  logic        s_start, s_ready, s_done;
  logic [4:0]  s_a, s_b, s_res;
  logic [15:0] s_seed;

  rand_order_gf_mul #(.M(5), .TAP(2)) dut (
    .clk(clk), .rst(rst), .start(s_start), .ready(s_ready),
    .op_a(s_a), .op_b(s_b), .seed(s_seed), .result(s_res), .done(s_done)
  );

  // Full-size instance with default parameters
  logic          b_start, b_ready, b_done;
  logic [232:0]  b_a, b_b, b_res;
  logic [15:0]   b_seed;

  rand_order_gf_mul dut_big (
    .clk(clk), .rst(rst), .start(b_start), .ready(b_ready),
    .op_a(b_a), .op_b(b_b), .seed(b_seed), .result(b_res), .done(b_done)
  );

  function automatic logic [255:0] ref_mul(input logic [255:0] a, input logic [255:0] b,
                                           input int m, input int tap);
    logic [511:0] p;
    p = '0;
    for (int i = 0; i < m; i++)
      for (int j = 0; j < m; j++)
        p[i+j] = p[i+j] ^ (a[i] & b[j]);
    for (int i = 2*m - 2; i >= m; i--) begin
      if (p[i]) begin
        p[i] = 1'b0;
        p[i-m] = ~p[i-m];
        p[i-m+tap] = ~p[i-m+tap];
      end
    end
    for (int i = m; i < 256; i++) p[i] = 1'b0;
    return p[255:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_small(input logic [4:0] a, input logic [4:0] b, input logic [15:0] sd,
                           input bit inject, output logic [4:0] r);
    int lat;
    logic [4:0] held;
    bit extra;
    @(negedge clk);
    s_a = a; s_b = b; s_seed = sd; s_start = 1'b1;
    @(negedge clk);
    s_start = 1'b0;
    lat = 0;
    chk(!s_ready, "R2 ready low after accept", s_ready, 0);
    while (!s_done && lat < 60) begin
      if (inject && lat == 3) begin
        s_start = 1'b1; s_a = ~a; s_b = b ^ 5'h15; s_seed = ~sd;
      end else begin
        s_start = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    s_start = 1'b0;
    r = s_res;
    chk(lat == 17, "R3 latency", lat, 17);
    chk(s_ready, "R3 ready back with done", s_ready, 1);
    chk(r == ref_mul(a, b, 5, 2), "R4 small product", r, ref_mul(a, b, 5, 2));
    held = s_res;
    @(negedge clk);
    chk(!s_done, "R3 done one cycle", s_done, 0);
    chk(s_res == held, "R7 result held", s_res, held);
    if (inject) begin
      extra = 1'b0;
      repeat (25) begin
        @(negedge clk);
        if (s_done || !s_ready) extra = 1'b1;
      end
      chk(!extra, "R6 busy start ignored", extra, 0);
      chk(s_res == held, "R6 result after ignored start", s_res, held);
    end
  endtask

  task automatic run_big(input logic [232:0] a, input logic [232:0] b, input logic [15:0] sd);
    int lat;
    logic [255:0] e;
    @(negedge clk);
    b_a = a; b_b = b; b_seed = sd; b_start = 1'b1;
    @(negedge clk);
    b_start = 1'b0;
    lat = 0;
    while (!b_done && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    e = ref_mul(a, b, 233, 74);
    chk(lat == 17, "R3 latency full size", lat, 17);
    chk(b_res == e[232:0], "R4 full-size product", b_res, e);
  endtask

  function automatic logic [232:0] rnd233();
    logic [255:0] v;
    for (int k = 0; k < 8; k++) v[k*32 +: 32] = $urandom;
    return v[232:0];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [4:0] r, r0;
    s_start = 0; s_a = 0; s_b = 0; s_seed = 0;
    b_start = 0; b_a = 0; b_b = 0; b_seed = 0;
    rst = 1'b1;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(s_ready && b_ready, "R1 ready after reset", {s_ready, b_ready}, 2'b11);
    chk(!s_done && !b_done, "R1 done low after reset", {s_done, b_done}, 0);
    chk(s_res == 0 && b_res == 0, "R1 result zero after reset", s_res | b_res, 0);

    // R8: zero seed first, then every operand pair with a changing seed (R4)
    for (int ia = 0; ia < 32; ia++) begin
      for (int ib = 0; ib < 32; ib++) begin
        run_small(5'(ia), 5'(ib), 16'((ia * 32 + ib) * 16'h3b1), ((ia * 32 + ib) % 97) == 5, r);
      end
    end

    // R5: same operands under many seeds give one answer
    run_small(5'h1b, 5'h17, 16'h0001, 1'b0, r0);
    for (int k = 0; k < 16; k++) begin
      run_small(5'h1b, 5'h17, 16'(k * 16'h1d3b + 7), 1'b0, r);
      chk(r == r0, "R5 seed independence", r, r0);
    end
    run_small(5'h1f, 5'h1f, 16'h0000, 1'b0, r);
    chk(r == ref_mul(5'h1f, 5'h1f, 5, 2), "R8 zero seed product", r, ref_mul(5'h1f, 5'h1f, 5, 2));

    // Full-size vectors: extremes then pseudo-random
    run_big({233{1'b1}}, {233{1'b1}}, 16'h0000);
    run_big(233'(1) << 232, 233'(1) << 232, 16'h1234);
    run_big(233'(1) << 232, 233'h2, 16'h8001);
    run_big(233'h1, rnd233(), 16'hbeef);
    run_big(233'h0, rnd233(), 16'h5555);
    for (int k = 0; k < 8; k++) run_big(rnd233(), rnd233(), 16'(k * 977 + 3));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule